// File: doc/BRIEF.md
# Serial-Port Transmit/Receive Byte Queue Pair

This block sits behind a byte-level serial port slave and gives that port two 64-entry byte queues. The transmit queue can only be written from the serial side and is drained by the radio datapath. The receive queue is filled by the radio datapath and can only be read from the serial side. The first byte of each transaction is a header. Its low six bits select the queue address, its top bit chooses read or write, and bit 6 chooses between one data byte and a stream of data bytes.

The serial shifter outside the block delivers each finished byte with a one-cycle valid strobe. It shifts out whatever `byte_out` holds during the next byte frame. While transmit data is being written, `byte_out` carries a status byte whose free-space field counts the room left before the byte now being shifted in. While receive data is being read, it carries the oldest receive byte.

Flush strobes from the command decoder empty each queue, but only while the radio controller reports one of three permitted states. A rising edge on the sleep input empties both queues and clears both error flags.

Top module: `spi_fifo_pair`

## Requirements
- R1: A header whose bits [5:0] equal 0x3F opens a queue access. Bit 7 = 0 selects a transmit write and bit 7 = 1 selects a receive read, so 0x3F/0x7F write and 0xBF/0xFF read.
- R2: With header bit 6 = 0 (single access), exactly one data byte is transferred. The byte after it is decoded as a new header while chip select stays low.
- R3: With header bit 6 = 1 (burst), every following byte is data until chip select goes high. A high chip select always returns the block to header decoding.
- R4: Outside a receive read, `byte_out` is a status byte. Bit 7 is 0, bits [6:4] hold `radio_state`, and bits [3:0] hold min(64 - tx count, 15) taken before the byte in flight. When the last byte that fits is being written, the field reads 1.
- R5: A transmit write to a full queue is dropped and sets `tx_ovf`, which stays set until a transmit flush or sleep entry.
- R6: During a receive read, `byte_out` shows the oldest receive byte, and each data byte pops it. When the queue is empty, `byte_out` is 0x00 and a read sets `rx_unf`, which stays set until a receive flush or sleep entry.
- R7: `flush_tx`/`flush_rx` take effect only when `radio_state` is 0 (idle), 6 (receive overflow) or 7 (transmit underflow). In any other state the queues and flags are unchanged.
- R8: A rising edge of `sleep` empties both queues and clears `tx_ovf` and `rx_unf`.
- R9: The radio ports keep first-in-first-out order. `tx_dout` is the oldest transmit byte, or 0x00 when empty. A pop on an empty transmit queue and a push on a full receive queue are ignored. `rx_full` is high at 64 entries.
- R10: A header whose bits [5:0] differ from 0x3F makes the block ignore every byte until chip select goes high.
- R11: After reset both queues are empty, both flags are low and the block waits for a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| byte_vld | input | 1 | One-cycle strobe: a serial byte has been received |
| byte_in | input | 8 | Received serial byte |
| byte_out | output | 8 | Byte to shift out in the current frame |
| radio_state | input | 3 | Radio controller state code |
| flush_tx | input | 1 | Transmit flush strobe |
| flush_rx | input | 1 | Receive flush strobe |
| sleep | input | 1 | Sleep level; its rising edge flushes both queues |
| tx_pop | input | 1 | Radio takes the oldest transmit byte |
| tx_dout | output | 8 | Oldest transmit byte |
| tx_empty | output | 1 | Transmit queue empty |
| rx_push | input | 1 | Radio stores a receive byte |
| rx_din | input | 8 | Receive byte from radio |
| rx_full | output | 1 | Receive queue full |
| tx_ovf | output | 1 | Sticky transmit overflow flag |
| rx_unf | output | 1 | Sticky receive underflow flag |

## Verification
The header decoder is tried with all four queue headers, with a foreign header, and with a single access followed directly by another byte. These separate single from burst handling and decoding from skipping. A long transmit burst that runs past capacity shows where the free-space field saturates, where it reaches one and where bytes start to drop. Receive reads run past the last byte, and flush strobes are repeated under allowed and forbidden radio states, so gating errors and flag clearing show up as differences from the model. Sleep is raised with data held in both queues.

// File: rtl/spi_fifo_pair_pkg.sv
package spi_fifo_pair_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned STATE_W = 3;
  localparam logic [5:0]  QADDR   = 6'h3F;
  localparam logic [STATE_W-1:0] ST_IDLE   = 3'd0;
  localparam logic [STATE_W-1:0] ST_RX_OVF = 3'd6;
  localparam logic [STATE_W-1:0] ST_TX_UNF = 3'd7;

  typedef enum logic [1:0] {
    M_HDR  = 2'd0,
    M_TXW  = 2'd1,
    M_RXR  = 2'd2,
    M_SKIP = 2'd3
  } acc_mode_t;
endpackage

// File: rtl/sfp_queue.sv
module sfp_queue #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic [CW-1:0] cnt,
  output logic          full,
  output logic          empty,
  output logic          push_drop,
  output logic          pop_miss
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q, wp_n, rp_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          push_ok, pop_ok;

  assign full      = (cnt_q == CW'(DEPTH));
  assign empty     = (cnt_q == '0);
  assign push_ok   = push & ~full & ~flush;
  assign pop_ok    = pop & ~empty & ~flush;
  assign push_drop = push & full & ~flush;
  assign pop_miss  = pop & empty & ~flush;
  assign cnt       = cnt_q;
  assign dout      = empty ? '0 : mem[rp_q];

  always_comb begin
    wp_n  = wp_q;
    rp_n  = rp_q;
    cnt_n = cnt_q;
    if (flush) begin
      wp_n  = '0;
      rp_n  = '0;
      cnt_n = '0;
    end else begin
      if (push_ok) wp_n = (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
      if (pop_ok)  rp_n = (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
      cnt_n = cnt_q + CW'(push_ok) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp_q] <= din;
  end
endmodule

// File: rtl/sfp_access_ctrl.sv
module sfp_access_ctrl
  import spi_fifo_pair_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               byte_vld,
  input  logic [DATA_W-1:0]  byte_in,
  input  logic [STATE_W-1:0] radio_state,
  input  logic               flush_tx,
  input  logic               flush_rx,
  input  logic               sleep,
  output logic               spi_push,
  output logic               spi_pop,
  output logic               rd_mode,
  output logic               tx_clr,
  output logic               rx_clr
);
  acc_mode_t mode_q, mode_n;
  logic      burst_q, burst_n;
  logic      sleep_q;
  logic      st_ok, sleep_rise, take;

  assign take       = ~cs_n & byte_vld;
  assign spi_push   = take & (mode_q == M_TXW);
  assign spi_pop    = take & (mode_q == M_RXR);
  assign rd_mode    = (mode_q == M_RXR);
  assign st_ok      = (radio_state == ST_IDLE) | (radio_state == ST_RX_OVF) |
                      (radio_state == ST_TX_UNF);
  assign sleep_rise = sleep & ~sleep_q;
  assign tx_clr     = sleep_rise | (flush_tx & st_ok);
  assign rx_clr     = sleep_rise | (flush_rx & st_ok);

  always_comb begin
    mode_n  = mode_q;
    burst_n = burst_q;
    if (cs_n) begin
      mode_n = M_HDR;
    end else if (byte_vld) begin
      unique case (mode_q)
        M_HDR: begin
          if (byte_in[5:0] == QADDR) begin
            mode_n  = byte_in[7] ? M_RXR : M_TXW;
            burst_n = byte_in[6];
          end else begin
            mode_n = M_SKIP;
          end
        end
        M_TXW, M_RXR: if (!burst_q) mode_n = M_HDR;
        default:      mode_n = M_SKIP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= M_HDR;
      burst_q <= 1'b0;
      sleep_q <= 1'b0;
    end else begin
      mode_q  <= mode_n;
      burst_q <= burst_n;
      sleep_q <= sleep;
    end
  end
endmodule

// File: rtl/spi_fifo_pair.sv
module spi_fifo_pair
  import spi_fifo_pair_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               byte_vld,
  input  logic [DATA_W-1:0]  byte_in,
  output logic [DATA_W-1:0]  byte_out,
  input  logic [STATE_W-1:0] radio_state,
  input  logic               flush_tx,
  input  logic               flush_rx,
  input  logic               sleep,
  input  logic               tx_pop,
  output logic [DATA_W-1:0]  tx_dout,
  output logic               tx_empty,
  input  logic               rx_push,
  input  logic [DATA_W-1:0]  rx_din,
  output logic               rx_full,
  output logic               tx_ovf,
  output logic               rx_unf
);
  logic              rst_s1_q, rst_sync_n;
  logic              spi_push, spi_pop, rd_mode, tx_clr, rx_clr;
  logic [CW-1:0]     tx_cnt, rx_cnt, tx_free;
  logic              tx_full_w, rx_empty_w;
  logic              tx_drop, rx_miss, tx_miss_unused, rx_drop_unused;
  logic [DATA_W-1:0] rx_head;
  logic              ovf_q, ovf_n, unf_q, unf_n;
  logic [3:0]        free_sat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1_q   <= 1'b1;
      rst_sync_n <= rst_s1_q;
    end
  end

  sfp_access_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .cs_n(cs_n), .byte_vld(byte_vld),
    .byte_in(byte_in), .radio_state(radio_state), .flush_tx(flush_tx),
    .flush_rx(flush_rx), .sleep(sleep), .spi_push(spi_push),
    .spi_pop(spi_pop), .rd_mode(rd_mode), .tx_clr(tx_clr), .rx_clr(rx_clr)
  );

  sfp_queue #(.DW(DATA_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_sync_n), .flush(tx_clr), .push(spi_push),
    .din(byte_in), .pop(tx_pop), .dout(tx_dout), .cnt(tx_cnt),
    .full(tx_full_w), .empty(tx_empty), .push_drop(tx_drop),
    .pop_miss(tx_miss_unused)
  );

  sfp_queue #(.DW(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_sync_n), .flush(rx_clr), .push(rx_push),
    .din(rx_din), .pop(spi_pop), .dout(rx_head), .cnt(rx_cnt),
    .full(rx_full), .empty(rx_empty_w), .push_drop(rx_drop_unused),
    .pop_miss(rx_miss)
  );

  assign tx_free  = CW'(DEPTH) - tx_cnt;
  assign free_sat = (tx_free > CW'(15)) ? 4'hF : tx_free[3:0];
  assign byte_out = rd_mode ? rx_head : {1'b0, radio_state, free_sat};
  assign tx_ovf   = ovf_q;
  assign rx_unf   = unf_q;

  always_comb begin
    ovf_n = tx_clr ? 1'b0 : (ovf_q | tx_drop);
    unf_n = rx_clr ? 1'b0 : (unf_q | rx_miss);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      ovf_q <= ovf_n;
      unf_q <= unf_n;
    end
  end
endmodule

// File: rtl/spi_fifo_pair_chk.sv
module spi_fifo_pair_chk #(
  parameter int unsigned CW = 7
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       rd_mode,
  input logic [7:0] byte_out,
  input logic [2:0] radio_state,
  input logic       flush_tx,
  input logic       flush_rx,
  input logic       sleep,
  input logic       tx_empty,
  input logic [7:0] tx_dout,
  input logic [CW-1:0] rx_cnt,
  input logic       tx_ovf,
  input logic       rx_unf
);
  logic st_ok;
  assign st_ok = (radio_state == 3'd0) | (radio_state == 3'd6) | (radio_state == 3'd7);

  a_r3_cs_to_header: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !rd_mode);
  a_r4_status_msb: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_mode |-> (byte_out[7] == 1'b0 && byte_out[6:4] == radio_state));
  a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ovf && !flush_tx && !sleep) |=> tx_ovf);
  a_r6_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_unf && !flush_rx && !sleep) |=> rx_unf);
  a_r7_tx_flush_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_tx && st_ok) |=> (tx_empty && !tx_ovf));
  a_r7_rx_flush_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_rx && st_ok) |=> (rx_cnt == '0 && !rx_unf));
  a_r8_sleep_flush: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep) |=> (tx_empty && rx_cnt == '0 && !tx_ovf && !rx_unf));
  a_r9_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> (tx_dout == 8'h00));
endmodule

bind spi_fifo_pair spi_fifo_pair_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .cs_n(cs_n), .rd_mode(rd_mode),
  .byte_out(byte_out), .radio_state(radio_state), .flush_tx(flush_tx),
  .flush_rx(flush_rx), .sleep(sleep), .tx_empty(tx_empty),
  .tx_dout(tx_dout), .rx_cnt(rx_cnt), .tx_ovf(tx_ovf), .rx_unf(rx_unf)
);

// File: tb/spi_fifo_pair_tb_top.sv
`timescale 1ns/1ps
module spi_fifo_pair_tb_top;
  logic clk, rst_n, cs_n, byte_vld, flush_tx, flush_rx, sleep, tx_pop, rx_push;
  logic [7:0] byte_in, rx_din, byte_out, tx_dout;
  logic [2:0] radio_state;
  logic tx_empty, rx_full, tx_ovf, rx_unf;
  int n_tests = 0, n_fail = 0;

  spi_fifo_pair dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .byte_vld(byte_vld),
    .byte_in(byte_in), .byte_out(byte_out), .radio_state(radio_state),
    .flush_tx(flush_tx), .flush_rx(flush_rx), .sleep(sleep),
    .tx_pop(tx_pop), .tx_dout(tx_dout), .tx_empty(tx_empty),
    .rx_push(rx_push), .rx_din(rx_din), .rx_full(rx_full),
    .tx_ovf(tx_ovf), .rx_unf(rx_unf)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // reference model
  byte m_txq[$];
  byte m_rxq[$];
  int  m_mode;   // 0 header, 1 tx write, 2 rx read, 3 skip
  bit  m_burst, m_ovf, m_unf, m_sleep_q;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_txq.delete(); m_rxq.delete();
      m_mode = 0; m_burst = 0; m_ovf = 0; m_unf = 0; m_sleep_q = 0;
    end else begin
      bit rise, ok, sp, so;
      int pre;
      rise = sleep && !m_sleep_q;
      m_sleep_q = sleep;
      ok = (radio_state == 0) || (radio_state == 6) || (radio_state == 7);
      sp = !cs_n && byte_vld && (m_mode == 1);
      so = !cs_n && byte_vld && (m_mode == 2);
      if (rise || (flush_tx && ok)) begin
        m_txq.delete(); m_ovf = 0;
      end else begin
        pre = m_txq.size();
        if (tx_pop && pre > 0) void'(m_txq.pop_front());
        if (sp) begin
          if (pre < 64) m_txq.push_back(byte_in); else m_ovf = 1;
        end
      end
      if (rise || (flush_rx && ok)) begin
        m_rxq.delete(); m_unf = 0;
      end else begin
        pre = m_rxq.size();
        if (so) begin
          if (pre > 0) void'(m_rxq.pop_front()); else m_unf = 1;
        end
        if (rx_push && pre < 64) m_rxq.push_back(rx_din);
      end
      if (cs_n) m_mode = 0;
      else if (byte_vld) begin
        case (m_mode)
          0: if (byte_in[5:0] == 6'h3F) begin
               m_mode = byte_in[7] ? 2 : 1; m_burst = byte_in[6];
             end else m_mode = 3;
          1, 2: if (!m_burst) m_mode = 0;
          default: m_mode = 3;
        endcase
      end
    end
  end

  function automatic logic [7:0] exp_out();
    int fr;
    if (m_mode == 2) return (m_rxq.size() > 0) ? m_rxq[0] : 8'h00;
    fr = 64 - m_txq.size();
    return {1'b0, radio_state, (fr > 15) ? 4'hF : 4'(fr)};
  endfunction

  task automatic chk(input bit cond, input string req, input int act, input int exp);
    n_tests++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      logic [7:0] e;
      e = exp_out();
      chk(byte_out === e, "R4/R6 byte_out", byte_out, e);
      e = (m_txq.size() > 0) ? m_txq[0] : 8'h00;
      chk(tx_dout === e, "R9 tx_dout", tx_dout, e);
      chk(tx_empty === (m_txq.size() == 0), "R9 tx_empty", tx_empty, m_txq.size() == 0);
      chk(rx_full === (m_rxq.size() == 64), "R9 rx_full", rx_full, m_rxq.size() == 64);
      chk(tx_ovf === m_ovf, "R5 tx_ovf", tx_ovf, m_ovf);
      chk(rx_unf === m_unf, "R6 rx_unf", rx_unf, m_unf);
    end
  end

  task automatic xfer(input logic [7:0] b);
    @(negedge clk); cs_n = 1'b0; byte_vld = 1'b1; byte_in = b;
    @(negedge clk); byte_vld = 1'b0;
  endtask
  task automatic cs_high();
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk);
  endtask
  task automatic rpush(input logic [7:0] b);
    @(negedge clk); rx_push = 1'b1; rx_din = b;
    @(negedge clk); rx_push = 1'b0;
  endtask
  task automatic tpop();
    @(negedge clk); tx_pop = 1'b1;
    @(negedge clk); tx_pop = 1'b0;
  endtask
  task automatic strobe(input bit t, input bit r);
    @(negedge clk); flush_tx = t; flush_rx = r;
    @(negedge clk); flush_tx = 1'b0; flush_rx = 1'b0;
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; cs_n = 1; byte_vld = 0; byte_in = 0; radio_state = 0;
    flush_tx = 0; flush_rx = 0; sleep = 0; tx_pop = 0; rx_push = 0; rx_din = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk(tx_empty && !rx_full && !tx_ovf && !rx_unf, "R11 reset flags", {tx_empty, rx_full, tx_ovf, rx_unf}, 4'b1000);
    chk(byte_out == 8'h0F, "R11 reset status", byte_out, 8'h0F);
    // R1 R2 single write, then the next byte is a header
    xfer(8'h3F); xfer(8'hA5);
    chk(tx_dout == 8'hA5, "R1 single tx write", tx_dout, 8'hA5);
    // R10 foreign header: following bytes are skipped
    xfer(8'h12); xfer(8'h3F); xfer(8'h77);
    tpop();
    chk(tx_empty, "R10 skipped bytes not stored", tx_empty, 1);
    cs_high();
    // R4 burst write to capacity, then R5 overflow
    radio_state = 3'd2;
    xfer(8'h7F);
    for (int i = 0; i < 63; i++) xfer(8'(i + 1));
    chk(byte_out == 8'h21, "R4 last-fit status reads one", byte_out, 8'h21);
    xfer(8'h40);
    chk(byte_out == 8'h20 && !tx_ovf, "R4 full status", byte_out, 8'h20);
    xfer(8'hEE);
    chk(tx_ovf, "R5 overflow flag", tx_ovf, 1);
    cs_high();
    // R7 flush in forbidden state ignored
    strobe(1'b1, 1'b0);
    chk(!tx_empty && tx_ovf, "R7 forbidden tx flush ignored", tx_empty, 0);
    tpop(); tpop();
    chk(tx_dout == 8'h03, "R9 tx order", tx_dout, 8'h03);
    radio_state = 3'd7;
    strobe(1'b1, 1'b0);
    chk(tx_empty && !tx_ovf, "R7 allowed tx flush", tx_empty, 1);
    tpop();
    // R6 receive reads
    radio_state = 3'd0;
    rpush(8'h11); rpush(8'h22); rpush(8'h33);
    @(negedge clk); cs_n = 1'b0;
    xfer(8'hBF);
    chk(byte_out == 8'h11, "R6 head shown", byte_out, 8'h11);
    xfer(8'h00);
    chk(byte_out[7] == 1'b0 && byte_out[3:0] == 4'hF, "R2 back to header after read", byte_out, 8'h0F);
    xfer(8'hFF);
    chk(byte_out == 8'h22, "R6 burst head", byte_out, 8'h22);
    xfer(8'h00); xfer(8'h00);
    chk(byte_out == 8'h00, "R6 empty reads zero", byte_out, 0);
    xfer(8'h00);
    chk(rx_unf, "R6 underflow flag", rx_unf, 1);
    // R3 chip select ends the burst
    cs_high();
    chk(byte_out == 8'h0F, "R3 header after cs high", byte_out, 8'h0F);
    xfer(8'h3F); xfer(8'h5A); xfer(8'h7F); xfer(8'h5B);
    cs_high();
    xfer(8'h3F); xfer(8'h5C);
    cs_high();
    // R9 fill receive queue
    for (int i = 0; i < 66; i++) rpush(8'(8'h80 + i));
    chk(rx_full, "R9 rx full", rx_full, 1);
    radio_state = 3'd4;
    strobe(1'b0, 1'b1);
    chk(rx_full && rx_unf, "R7 forbidden rx flush ignored", rx_full, 1);
    radio_state = 3'd6;
    strobe(1'b0, 1'b1);
    chk(!rx_full && !rx_unf, "R7 allowed rx flush", rx_full, 0);
    // R8 sleep entry
    rpush(8'h44);
    xfer(8'h7F);
    for (int i = 0; i < 66; i++) xfer(8'h99);
    cs_high();
    chk(tx_ovf && !tx_empty, "R8 precondition", tx_ovf, 1);
    radio_state = 3'd1;
    @(negedge clk); sleep = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(tx_empty && !tx_ovf && !rx_unf, "R8 sleep flush", tx_empty, 1);
    sleep = 1'b0;
    @(negedge clk); cs_n = 1'b0;
    xfer(8'hBF);
    chk(byte_out == 8'h00, "R8 rx emptied by sleep", byte_out, 0);
    cs_high();
    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule